// File: doc/BRIEF.md
# SDRAM Command Monitor

This block sits on the command pins of a four-bank SDRAM and watches them on every clock edge. It turns each cycle's pin pattern into one decoded command. The decode uses the clock-enable level from the previous cycle and the level in the current cycle. The block passes on the selected bank, the auto-precharge / all-banks flag and the row or column address. It keeps track of which banks hold an open row.

The same state is used to check sequencing rules as commands arrive:
- Mode-register writes and refreshes need every bank closed.
- A mode-register write is followed by a two-cycle quiet window.
- Activates must target closed banks.
- Reads and writes must target open banks.
- Only a clean exit is accepted out of a clock-low state.

A broken rule gives a one-cycle violation pulse with a 3-bit reason code, one clock after the offending command. A command that breaks a rule does not change the bank state or the mode-register lockout.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With clock enable high in both the previous and current cycle, `cmd_o` decodes {cs_n, ras_n, cas_n, we_n} as follows:
  - 0000 mode set = 2
  - 0001 auto refresh = 3
  - 0011 activate = 6
  - 0101 read = 7
  - 0100 write = 8
  - 0110 burst stop = 9
  - 0010 precharge = 10
  - 0111 NOP = 1
  - cs_n high: deselect = 0
- R2: Clock enable falling decodes as self-refresh entry (4) for the 0001 pattern and as power-down entry (11) otherwise. Clock enable low in both cycles reads as NOP (1). Clock enable rising decodes as self-refresh exit (5) when self-refresh was entered without violation, and as power-down exit (12) otherwise.
- R3: `bank_o` follows ba_i. `addr_o` is a_i[10:0] for activate, {3'b000, a_i[7:0]} for read/write, and 0 otherwise. `auto_pre_o` is a_i[10] for read, write and precharge, and 0 otherwise.
- R4: A mode set while any bank is open gives violation code 1.
- R5: In the two cycles after an accepted mode set, any command other than NOP or deselect gives code 2.
- R6: Auto refresh or self-refresh entry while any bank is open gives code 3.
- R7: Activating a bank that is already open gives code 4.
- R8: A read or write to a closed bank gives code 5.
- R9: Banks are closed as follows:
  - A read or write with a_i[10] high closes its bank.
  - Precharge with a_i[10] high closes all banks.
  - Precharge with a_i[10] low closes only the bank on ba_i.
- R10: Code 6 is given for either of these:
  - Clock enable falls with a pattern that is not NOP, deselect or 0001.
  - Clock enable rises with a pattern that is not NOP or deselect.
- R11: The violation is a registered one-cycle pulse following the command. `viol_code_o` is 0 when there is no violation. Code 6 takes priority over code 2, and code 2 takes priority over codes 1, 3, 4 and 5. A violating command does not change the bank state.
- R12: After reset, all banks are closed and no violation is signalled. The previous clock-enable level is taken as high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable pin |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank select |
| a_i | input | 11 | Address pins, bit 10 is the precharge qualifier |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | 2 | Selected bank |
| auto_pre_o | output | 1 | Auto-precharge / all-banks flag |
| addr_o | output | 11 | Row or column address |
| viol_o | output | 1 | Violation pulse |
| viol_code_o | output | 3 | Violation reason |

## Verification
The bench sweeps every chip-select and strobe pattern under each clock-enable transition. It checks the decoded code, and the violation that a falling or rising clock-enable with a bad pattern should produce. A decoder that ignored the previous clock-enable level would report normal commands during those edges.

Every bank is opened, reopened, accessed with auto-precharge and then accessed again. A tracker indexed wrongly, or one that kept auto-precharged banks open, fails the second access.

The mode-set lockout is probed on its second cycle and on the first cycle after it. An off-by-one window, or a locked activate that still opened its bank, shows up as a wrong code. Priority is probed with a bad power-down entry inside the lockout.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;
  typedef enum logic [3:0] {
    CMD_DESEL    = 4'd0,
    CMD_NOP      = 4'd1,
    CMD_MRS      = 4'd2,
    CMD_AREF     = 4'd3,
    CMD_SREF_IN  = 4'd4,
    CMD_SREF_OUT = 4'd5,
    CMD_ACT      = 4'd6,
    CMD_RD       = 4'd7,
    CMD_WR       = 4'd8,
    CMD_BST      = 4'd9,
    CMD_PRE      = 4'd10,
    CMD_PD_IN    = 4'd11,
    CMD_PD_OUT   = 4'd12
  } cmd_e;

  typedef enum logic [2:0] {
    ERR_NONE       = 3'd0,
    ERR_MRS_OPEN   = 3'd1,
    ERR_MRS_LOCK   = 3'd2,
    ERR_REF_OPEN   = 3'd3,
    ERR_ACT_OPEN   = 3'd4,
    ERR_ACC_CLOSED = 3'd5,
    ERR_LOWPWR     = 3'd6
  } err_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
#(
  parameter int ROW_W = 11,
  parameter int COL_W = 8
) (
  input  logic             cke_q_i,
  input  logic             cke_i,
  input  logic             cs_ni,
  input  logic             ras_ni,
  input  logic             cas_ni,
  input  logic             we_ni,
  input  logic             sr_i,
  input  logic [ROW_W-1:0] a_i,
  output cmd_e             cmd_o,
  output logic [ROW_W-1:0] addr_o,
  output logic             ap_o,
  output logic             lp_bad_o
);
  logic [2:0] strobes;
  logic       nop_like;
  logic       ref_pat;

  assign strobes  = {ras_ni, cas_ni, we_ni};
  assign nop_like = cs_ni | (strobes == 3'b111);
  assign ref_pat  = !cs_ni && (strobes == 3'b001);

  always_comb begin
    cmd_o    = CMD_NOP;
    lp_bad_o = 1'b0;
    unique case ({cke_q_i, cke_i})
      2'b11: begin
        if (cs_ni) cmd_o = CMD_DESEL;
        else begin
          case (strobes)
            3'b000:  cmd_o = CMD_MRS;
            3'b001:  cmd_o = CMD_AREF;
            3'b011:  cmd_o = CMD_ACT;
            3'b101:  cmd_o = CMD_RD;
            3'b100:  cmd_o = CMD_WR;
            3'b110:  cmd_o = CMD_BST;
            3'b010:  cmd_o = CMD_PRE;
            default: cmd_o = CMD_NOP;
          endcase
        end
      end
      2'b10: begin
        cmd_o    = ref_pat ? CMD_SREF_IN : CMD_PD_IN;
        lp_bad_o = !nop_like && !ref_pat;
      end
      2'b01: begin
        cmd_o    = sr_i ? CMD_SREF_OUT : CMD_PD_OUT;
        lp_bad_o = !nop_like;
      end
      default: cmd_o = CMD_NOP;
    endcase
  end

  always_comb begin
    addr_o = '0;
    ap_o   = 1'b0;
    case (cmd_o)
      CMD_ACT: addr_o = a_i;
      CMD_RD, CMD_WR: begin
        addr_o = {{(ROW_W-COL_W){1'b0}}, a_i[COL_W-1:0]};
        ap_o   = a_i[ROW_W-1];
      end
      CMD_PRE: ap_o = a_i[ROW_W-1];
      default: ;
    endcase
  end
endmodule

// File: rtl/sdram_rule_check.sv
module sdram_rule_check
  import sdram_mon_pkg::*;
#(
  parameter int BANKS = 4,
  localparam int BA_W = $clog2(BANKS)
) (
  input  cmd_e             cmd_i,
  input  logic [BA_W-1:0]  bank_i,
  input  logic             lp_bad_i,
  input  logic             lock_i,
  input  logic [BANKS-1:0] open_i,
  output err_e             err_o
);
  logic any_open;
  assign any_open = |open_i;

  always_comb begin
    err_o = ERR_NONE;
    if (lp_bad_i) err_o = ERR_LOWPWR;
    else if (lock_i && cmd_i != CMD_NOP && cmd_i != CMD_DESEL) err_o = ERR_MRS_LOCK;
    else begin
      case (cmd_i)
        CMD_MRS:              if (any_open) err_o = ERR_MRS_OPEN;
        CMD_AREF, CMD_SREF_IN: if (any_open) err_o = ERR_REF_OPEN;
        CMD_ACT:              if (open_i[bank_i]) err_o = ERR_ACT_OPEN;
        CMD_RD, CMD_WR:       if (!open_i[bank_i]) err_o = ERR_ACC_CLOSED;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_mon_pkg::*;
#(
  parameter int BANKS = 4,
  localparam int BA_W = $clog2(BANKS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             commit_i,
  input  cmd_e             cmd_i,
  input  logic [BA_W-1:0]  bank_i,
  input  logic             ap_i,
  output logic [BANKS-1:0] open_o
);
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (bank_i == BA_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) open_o[b] <= 1'b0;
      else if (commit_i) begin
        case (cmd_i)
          CMD_ACT:        if (hit) open_o[b] <= 1'b1;
          CMD_RD, CMD_WR: if (hit && ap_i) open_o[b] <= 1'b0;
          CMD_PRE:        if (hit || ap_i) open_o[b] <= 1'b0;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int BANKS   = 4,
  parameter int ROW_W   = 11,
  parameter int COL_W   = 8,
  parameter int MRS_GAP = 2,
  localparam int BA_W   = $clog2(BANKS),
  localparam int LOCK_W = $clog2(MRS_GAP + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cke_i,
  input  logic             cs_ni,
  input  logic             ras_ni,
  input  logic             cas_ni,
  input  logic             we_ni,
  input  logic [BA_W-1:0]  ba_i,
  input  logic [ROW_W-1:0] a_i,
  output logic [3:0]       cmd_o,
  output logic [BA_W-1:0]  bank_o,
  output logic             auto_pre_o,
  output logic [ROW_W-1:0] addr_o,
  output logic             viol_o,
  output logic [2:0]       viol_code_o
);
  cmd_e              cmd;
  err_e              err;
  logic              cke_q;
  logic              sr_q;
  logic              lp_bad;
  logic              lock_active;
  logic [LOCK_W-1:0] lock_cnt_q;
  logic [BANKS-1:0]  bank_open;

  assign lock_active = (lock_cnt_q != '0);

  sdram_cmd_decode #(.ROW_W(ROW_W), .COL_W(COL_W)) u_dec (
    .cke_q_i (cke_q),
    .cke_i   (cke_i),
    .cs_ni   (cs_ni),
    .ras_ni  (ras_ni),
    .cas_ni  (cas_ni),
    .we_ni   (we_ni),
    .sr_i    (sr_q),
    .a_i     (a_i),
    .cmd_o   (cmd),
    .addr_o  (addr_o),
    .ap_o    (auto_pre_o),
    .lp_bad_o(lp_bad)
  );

  sdram_rule_check #(.BANKS(BANKS)) u_rules (
    .cmd_i   (cmd),
    .bank_i  (ba_i),
    .lp_bad_i(lp_bad),
    .lock_i  (lock_active),
    .open_i  (bank_open),
    .err_o   (err)
  );

  sdram_bank_track #(.BANKS(BANKS)) u_banks (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .commit_i(err == ERR_NONE),
    .cmd_i   (cmd),
    .bank_i  (ba_i),
    .ap_i    (auto_pre_o),
    .open_o  (bank_open)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q       <= 1'b1;
      sr_q        <= 1'b0;
      lock_cnt_q  <= '0;
      viol_o      <= 1'b0;
      viol_code_o <= 3'd0;
    end else begin
      cke_q       <= cke_i;
      viol_o      <= (err != ERR_NONE);
      viol_code_o <= err;
      if (cmd == CMD_MRS && err == ERR_NONE) lock_cnt_q <= LOCK_W'(MRS_GAP);
      else if (lock_active) lock_cnt_q <= lock_cnt_q - 1'b1;
      if (cmd == CMD_SREF_IN && err == ERR_NONE) sr_q <= 1'b1;
      else if (cmd == CMD_SREF_OUT) sr_q <= 1'b0;
    end
  end

  assign cmd_o  = cmd;
  assign bank_o = ba_i;
endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk
  import sdram_mon_pkg::*;
#(
  parameter int BANKS = 4,
  localparam int BA_W = $clog2(BANKS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [3:0]       cmd_i,
  input logic [BA_W-1:0]  bank_i,
  input logic             ap_i,
  input logic             viol_i,
  input logic [2:0]       code_i,
  input logic             lock_i,
  input logic [BANKS-1:0] open_i
);
  a_r11_code_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !viol_i |-> code_i == 3'd0);

  a_r4_mrs_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_MRS && |open_i && !lock_i) |=> (viol_i && code_i == 3'd1));

  a_r5_lock_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && (cmd_i == CMD_ACT || cmd_i == CMD_RD || cmd_i == CMD_WR || cmd_i == CMD_MRS))
    |=> (viol_i && code_i == 3'd2));

  a_r6_ref_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd_i == CMD_AREF || cmd_i == CMD_SREF_IN) && |open_i && !lock_i)
    |=> (viol_i && code_i == 3'd3));

  a_r7_act_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_ACT && open_i[bank_i] && !lock_i) |=> (viol_i && code_i == 3'd4));

  a_r8_access_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd_i == CMD_RD || cmd_i == CMD_WR) && !open_i[bank_i] && !lock_i)
    |=> (viol_i && code_i == 3'd5));

  a_r9_pre_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_PRE && ap_i && !lock_i) |=> open_i == '0);

  a_r11_act_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_ACT && lock_i && !open_i[bank_i]) |=> !open_i[$past(bank_i)]);
endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(.BANKS(BANKS)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .cmd_i (cmd_o),
  .bank_i(bank_o),
  .ap_i  (auto_pre_o),
  .viol_i(viol_o),
  .code_i(viol_code_o),
  .lock_i(lock_active),
  .open_i(bank_open)
);

// File: tb/sdram_cmd_monitor_test.sv
module sdram_cmd_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] P_DES = 4'b1111, P_NOP = 4'b0111, P_MRS = 4'b0000,
                         P_REF = 4'b0001, P_ACT = 4'b0011, P_RD  = 4'b0101,
                         P_WR  = 4'b0100, P_PRE = 4'b0010;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cke = 1'b1, cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [10:0] a = '0;
  logic [3:0]  cmd_o;
  logic [1:0]  bank_o;
  logic        auto_pre_o, viol_o;
  logic [10:0] addr_o;
  logic [2:0]  viol_code_o;

  int checks = 0, fails = 0;
  logic [3:0]  g_cmd;
  logic [1:0]  g_bank;
  logic        g_ap, g_v;
  logic [10:0] g_addr;
  logic [2:0]  g_code;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_monitor uut (
    .clk_i(clk), .rst_ni(rst_ni), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
    .cas_ni(cas_n), .we_ni(we_n), .ba_i(ba), .a_i(a), .cmd_o(cmd_o),
    .bank_o(bank_o), .auto_pre_o(auto_pre_o), .addr_o(addr_o),
    .viol_o(viol_o), .viol_code_o(viol_code_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_v(input string req, input int exp_code);
    chk(req, {g_v, g_code}, {exp_code != 0, 3'(exp_code)});
  endtask

  task automatic drive(input logic k, input logic [3:0] p, input logic [1:0] b,
                       input logic [10:0] ad);
    @(negedge clk);
    cke = k; {cs_n, ras_n, cas_n, we_n} = p; ba = b; a = ad;
    #1;
    g_cmd = cmd_o; g_bank = bank_o; g_ap = auto_pre_o; g_addr = addr_o;
    @(posedge clk);
    #1;
    g_v = viol_o; g_code = viol_code_o;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; cke = 1'b1; {cs_n, ras_n, cas_n, we_n} = P_NOP;
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  function automatic int exp_cmd(input logic [3:0] p);
    if (p[3]) return 0;
    case (p[2:0])
      3'b000: return 2;
      3'b001: return 3;
      3'b011: return 6;
      3'b101: return 7;
      3'b100: return 8;
      3'b110: return 9;
      3'b010: return 10;
      default: return 1;
    endcase
  endfunction

  function automatic logic nop_like(input logic [3:0] p);
    return p[3] || p[2:0] == 3'b111;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    // R12 reset state
    chk("R12 viol after reset", {viol_o, viol_code_o}, 0);
    rst_ni = 1'b1;

    // R1 R3 decode sweep, clock enable held high
    for (int p = 0; p < 16; p++) begin
      drive(1'b1, 4'(p), 2'(p), 11'h5A5 ^ 11'(p * 37));
      chk("R1 cmd", g_cmd, exp_cmd(4'(p)));
      chk("R3 bank", g_bank, p % 4);
      case (exp_cmd(4'(p)))
        6: chk("R3 row addr", g_addr, 11'h5A5 ^ 11'(p * 37));
        7, 8: chk("R3 col addr", g_addr, (11'h5A5 ^ 11'(p * 37)) & 11'h0FF);
        default: chk("R3 addr zero", g_addr, 0);
      endcase
      if (exp_cmd(4'(p)) inside {7, 8, 10}) chk("R3 ap", g_ap, ((11'h5A5 ^ 11'(p * 37)) >> 10) & 1);
      else chk("R3 ap zero", g_ap, 0);
    end

    // R2 R10 falling edge sweep, then clean exit
    for (int p = 0; p < 16; p++) begin
      do_reset();
      drive(1'b1, P_NOP, 2'd0, 11'd0);
      drive(1'b0, 4'(p), 2'd0, 11'd0);
      chk("R2 entry cmd", g_cmd, (4'(p) == P_REF) ? 4 : 11);
      chk_v("R10 entry", (nop_like(4'(p)) || 4'(p) == P_REF) ? 0 : 6);
      drive(1'b0, 4'(p), 2'd0, 11'd0);
      chk("R2 held low", g_cmd, 1);
      drive(1'b1, P_NOP, 2'd0, 11'd0);
      chk("R2 exit cmd", g_cmd, (4'(p) == P_REF) ? 5 : 12);
      chk_v("R2 exit clean", 0);
    end

    // R10 rising edge sweep
    for (int p = 0; p < 16; p++) begin
      do_reset();
      drive(1'b0, P_NOP, 2'd0, 11'd0);
      drive(1'b1, 4'(p), 2'd1, 11'd0);
      chk("R2 pd exit", g_cmd, 12);
      chk_v("R10 exit", nop_like(4'(p)) ? 0 : 6);
    end

    // R7 R8 R9 every bank
    do_reset();
    for (int b = 0; b < 4; b++) begin
      drive(1'b1, P_RD, 2'(b), 11'd0);  chk_v("R8 read closed", 5);
      drive(1'b1, P_ACT, 2'(b), 11'h123); chk_v("R7 act closed ok", 0);
      drive(1'b1, P_ACT, 2'(b), 11'h123); chk_v("R7 act open", 4);
      drive(1'b1, P_RD, 2'(b), 11'h010); chk_v("R8 read open", 0);
      drive(1'b1, P_WR, 2'(b), 11'h410); chk_v("R9 write ap", 0);
      drive(1'b1, P_WR, 2'(b), 11'h010); chk_v("R9 closed by ap", 5);
    end
    drive(1'b1, P_ACT, 2'd0, 11'd0);
    drive(1'b1, P_ACT, 2'd3, 11'd0);
    drive(1'b1, P_PRE, 2'd0, 11'd0); chk_v("R9 pre single", 0);
    drive(1'b1, P_RD, 2'd3, 11'd0); chk_v("R9 other bank open", 0);
    drive(1'b1, P_RD, 2'd0, 11'd0); chk_v("R9 target closed", 5);
    drive(1'b1, P_NOP, 2'd0, 11'd0); chk_v("R11 pulse ends", 0);
    drive(1'b1, P_PRE, 2'd1, 11'h400); chk_v("R9 pre all", 0);
    drive(1'b1, P_RD, 2'd3, 11'd0); chk_v("R9 all closed", 5);

    // R6 refresh rules
    drive(1'b1, P_ACT, 2'd1, 11'd0);
    drive(1'b1, P_REF, 2'd0, 11'd0); chk_v("R6 aref open", 3);
    drive(1'b0, P_REF, 2'd0, 11'd0); chk_v("R6 sref open", 3);
    drive(1'b1, P_NOP, 2'd0, 11'd0); chk("R2 exit after bad sref", g_cmd, 12);
    drive(1'b1, P_RD, 2'd1, 11'd0); chk_v("R11 bank kept", 0);
    drive(1'b1, P_PRE, 2'd0, 11'h400);
    drive(1'b1, P_REF, 2'd0, 11'd0); chk_v("R6 aref idle", 0);

    // R4 R5 mode set
    drive(1'b1, P_ACT, 2'd2, 11'd0);
    drive(1'b1, P_MRS, 2'd0, 11'd0); chk_v("R4 mrs open", 1);
    drive(1'b1, P_PRE, 2'd0, 11'h400);
    drive(1'b1, P_MRS, 2'd0, 11'd0); chk_v("R4 mrs idle", 0);
    drive(1'b1, P_NOP, 2'd0, 11'd0); chk_v("R5 nop in lock", 0);
    drive(1'b1, P_ACT, 2'd0, 11'd0); chk_v("R5 second lock cycle", 2);
    drive(1'b1, P_ACT, 2'd0, 11'd0); chk_v("R5 lock over R11 not opened", 0);
    drive(1'b1, P_PRE, 2'd0, 11'h400);
    drive(1'b1, P_MRS, 2'd0, 11'd0);
    drive(1'b1, P_RD, 2'd0, 11'd0); chk_v("R5 first lock cycle", 2);
    drive(1'b1, P_DES, 2'd0, 11'd0); chk_v("R5 deselect in lock", 0);
    drive(1'b1, P_MRS, 2'd0, 11'd0);
    drive(1'b0, P_RD, 2'd0, 11'd0); chk_v("R11 priority lowpwr", 6);
    drive(1'b1, P_NOP, 2'd0, 11'd0); chk_v("R5 exit in lock", 2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule